// File: doc/BRIEF.md
# Register Rename Table with Free List

This block gives each decoded instruction physical register names in place of its architectural ones. It handles one instruction per cycle. The current physical name of each source is read from a map table in the same cycle. If the instruction writes a register, a fresh physical register is taken from a pool of unused ones and recorded as the new name of the destination. The name the destination had before is reported alongside, so that later stages can return it to the pool when the instruction retires.

Retirement hands superseded physical names back through a commit port, which appends them to the pool. A checkpoint port copies the map and the pool's read position in one step. A restore request later brings both back, which discards every name that was handed out after the copy was taken.

A two-state controller sequences the block. In RUN, decode proceeds normally. A restore request moves the controller from RUN to RECOVER (transition RESTORE_TAKEN). RECOVER lasts exactly one cycle, in which decode is held off, and then the controller returns to RUN (transition RECOVER_DONE). The default sizes are 8 architectural and 12 physical registers.

Top module: `reg_rename_unit`

## Requirements
- R1: After reset, architectural register i maps to physical register i. The pool holds physical registers ARCH_REGS to PHYS_REGS-1 and hands them out in ascending order.
- R2: The two source tags are the current map entries for the two source indices, driven combinationally in the same cycle.
- R3: If an instruction reads and writes the same architectural register, its source tag is the mapping held before its own remap.
- R4: An accepted instruction with a destination receives the pool's oldest free tag on the destination output. Its previous-tag output carries the old mapping. The new mapping is visible to the next cycle's lookups.
- R5: An accepted instruction without a destination consumes no tag and leaves the map unchanged.
- R6: An instruction that needs a destination is not accepted while the pool is empty, even if a commit returns a tag in that same cycle. An instruction without a destination is still accepted when the pool is empty.
- R7: Committed tags are appended to the pool and handed out in first-in first-out order. A commit and an allocation may happen in the same cycle.
- R8: A checkpoint request records the map and the pool read position as they stand after that cycle's decode.
- R9: A restore request reloads the map and pool position from the checkpoint. Decode is refused in the restore cycle and in the single RECOVER cycle that follows. After that, decode resumes in RUN.
- R10: When the valid input is low, nothing is accepted and neither the map nor the pool changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | An instruction is presented for renaming |
| dec_src_a | input | $clog2(ARCH_REGS) | First source architectural index |
| dec_src_b | input | $clog2(ARCH_REGS) | Second source architectural index |
| dec_dst | input | $clog2(ARCH_REGS) | Destination architectural index |
| dec_has_dst | input | 1 | The instruction writes a register |
| dec_accept | output | 1 | The presented instruction is renamed this cycle |
| ren_src_a | output | $clog2(PHYS_REGS) | Physical tag of first source |
| ren_src_b | output | $clog2(PHYS_REGS) | Physical tag of second source |
| ren_dst | output | $clog2(PHYS_REGS) | Newly allocated destination tag |
| ren_prev | output | $clog2(PHYS_REGS) | Destination mapping before this instruction |
| cm_valid | input | 1 | Return a physical tag to the pool |
| cm_tag | input | $clog2(PHYS_REGS) | Tag being returned |
| ckpt_save | input | 1 | Record map and pool position |
| ckpt_restore | input | 1 | Reload map and pool position from the record |

## Verification
Every decode result (accept, both source tags, destination tag and previous tag) is combinational and belongs to the cycle in which the instruction is presented. The bench drives inputs on the falling edge and samples these outputs shortly afterwards, before the next rising edge. Map updates, pool pushes and pops, and restores take effect at the rising edge. They are therefore checked one cycle later through the source tags and the destination tag that the next instructions receive. A restore is checked as a refused decode in its own cycle and in the following cycle, and as restored tags in the cycle after that.

// File: rtl/rename_pkg.sv
package rename_pkg;
    localparam int RN_ARCH_DEFAULT = 8;
    localparam int RN_PHYS_DEFAULT = 12;

    typedef enum logic {
        RN_RUN     = 1'b0,
        RN_RECOVER = 1'b1
    } rn_state_e;
endpackage

// File: rtl/rename_map.sv
module rename_map #(
    parameter int ARCH_REGS = rename_pkg::RN_ARCH_DEFAULT,
    parameter int PHYS_REGS = rename_pkg::RN_PHYS_DEFAULT,
    localparam int AW = $clog2(ARCH_REGS),
    localparam int TW = $clog2(PHYS_REGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_a,
    input  logic [AW-1:0] rd_b,
    input  logic [AW-1:0] rd_d,
    output logic [TW-1:0] tag_a,
    output logic [TW-1:0] tag_b,
    output logic [TW-1:0] tag_d,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [TW-1:0] wr_tag,
    input  logic          save,
    input  logic          restore
);
    logic [TW-1:0] map_q  [ARCH_REGS];
    logic [TW-1:0] snap_q [ARCH_REGS];

    // lookups see the table before this cycle's write (R3)
    assign tag_a = map_q[rd_a];
    assign tag_b = map_q[rd_b];
    assign tag_d = map_q[rd_d];

    for (genvar g = 0; g < ARCH_REGS; g++) begin : g_entry
        logic [TW-1:0] nxt;
        always_comb begin
            nxt = map_q[g];
            if (wr_en && (wr_idx == AW'(g)))
                nxt = wr_tag;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                map_q[g]  <= TW'(g);
                snap_q[g] <= TW'(g);
            end else if (restore) begin
                map_q[g]  <= snap_q[g];
            end else begin
                map_q[g]  <= nxt;
                if (save)
                    snap_q[g] <= nxt;
            end
        end

        a_r9_entry_restored: assert property (@(posedge clk) disable iff (!rst_n)
            restore |=> map_q[g] == $past(snap_q[g]));
    end

    a_r4_map_written: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !restore) |=> map_q[$past(wr_idx)] == $past(wr_tag));
endmodule

// File: rtl/rename_freelist.sv
module rename_freelist #(
    parameter int ARCH_REGS = rename_pkg::RN_ARCH_DEFAULT,
    parameter int PHYS_REGS = rename_pkg::RN_PHYS_DEFAULT,
    localparam int TW = $clog2(PHYS_REGS),
    localparam int PW = TW,
    localparam int DEPTH = 1 << PW,
    localparam int FREE_MAX = PHYS_REGS - ARCH_REGS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop,
    input  logic          push,
    input  logic [TW-1:0] push_tag,
    input  logic          save,
    input  logic          restore,
    output logic [TW-1:0] head_tag,
    output logic          empty
);
    logic [TW-1:0] slot_q [DEPTH];
    logic [PW:0]   head_q, tail_q, saved_q;
    logic [PW:0]   fill;

    assign fill     = tail_q - head_q;
    assign empty    = (fill == '0);
    assign head_tag = slot_q[head_q[PW-1:0]];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (i < FREE_MAX)
                    slot_q[i] <= TW'(ARCH_REGS + i);
                else
                    slot_q[i] <= '0;
            end
            head_q  <= '0;
            tail_q  <= (PW+1)'(FREE_MAX);
            saved_q <= '0;
        end else begin
            if (push) begin
                slot_q[tail_q[PW-1:0]] <= push_tag;
                tail_q <= tail_q + 1'b1;
            end
            if (restore)
                head_q <= saved_q;
            else if (pop)
                head_q <= head_q + 1'b1;
            if (save && !restore)
                saved_q <= pop ? head_q + 1'b1 : head_q;
        end
    end

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> fill < (PW+1)'(FREE_MAX));
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/reg_rename_unit.sv
module reg_rename_unit #(
    parameter int ARCH_REGS = rename_pkg::RN_ARCH_DEFAULT,
    parameter int PHYS_REGS = rename_pkg::RN_PHYS_DEFAULT,
    localparam int AW = $clog2(ARCH_REGS),
    localparam int TW = $clog2(PHYS_REGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dec_valid,
    input  logic [AW-1:0] dec_src_a,
    input  logic [AW-1:0] dec_src_b,
    input  logic [AW-1:0] dec_dst,
    input  logic          dec_has_dst,
    output logic          dec_accept,
    output logic [TW-1:0] ren_src_a,
    output logic [TW-1:0] ren_src_b,
    output logic [TW-1:0] ren_dst,
    output logic [TW-1:0] ren_prev,
    input  logic          cm_valid,
    input  logic [TW-1:0] cm_tag,
    input  logic          ckpt_save,
    input  logic          ckpt_restore
);
    import rename_pkg::*;

    rn_state_e state_q, state_n;
    logic      fl_empty;
    logic      alloc;
    logic      save_eff;
    logic      decode_open;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= RN_RUN;
        else
            state_q <= state_n;
    end

    // next state and outputs
    always_comb begin
        state_n     = state_q;
        decode_open = 1'b0;
        unique case (state_q)
            RN_RUN: begin
                if (ckpt_restore)
                    state_n = RN_RECOVER;   // RESTORE_TAKEN
                else
                    decode_open = 1'b1;
            end
            RN_RECOVER: begin
                state_n = RN_RUN;           // RECOVER_DONE
            end
            default: state_n = RN_RUN;
        endcase
    end

    assign dec_accept = dec_valid && decode_open && !ckpt_restore
                        && !(dec_has_dst && fl_empty);
    assign alloc      = dec_accept && dec_has_dst;
    assign save_eff   = ckpt_save && !ckpt_restore;

    rename_map #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_a    (dec_src_a),
        .rd_b    (dec_src_b),
        .rd_d    (dec_dst),
        .tag_a   (ren_src_a),
        .tag_b   (ren_src_b),
        .tag_d   (ren_prev),
        .wr_en   (alloc),
        .wr_idx  (dec_dst),
        .wr_tag  (ren_dst),
        .save    (save_eff),
        .restore (ckpt_restore)
    );

    rename_freelist #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_free (
        .clk      (clk),
        .rst_n    (rst_n),
        .pop      (alloc),
        .push     (cm_valid),
        .push_tag (cm_tag),
        .save     (save_eff),
        .restore  (ckpt_restore),
        .head_tag (ren_dst),
        .empty    (fl_empty)
    );

    a_r4_fresh_tag: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> ren_dst != ren_prev);
    a_r6_stall_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_has_dst && fl_empty) |-> !dec_accept);
    a_r9_recover_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_restore |=> !dec_accept);
    a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> !dec_accept);
endmodule

// File: tb/tb_reg_rename_unit.sv
module tb_reg_rename_unit;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       dec_valid, dec_has_dst, dec_accept;
    logic [2:0] dec_src_a, dec_src_b, dec_dst;
    logic [3:0] ren_src_a, ren_src_b, ren_dst, ren_prev;
    logic       cm_valid;
    logic [3:0] cm_tag;
    logic       ckpt_save, ckpt_restore;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    reg_rename_unit dut (
        .clk(clk), .rst_n(rst_n),
        .dec_valid(dec_valid), .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
        .dec_dst(dec_dst), .dec_has_dst(dec_has_dst), .dec_accept(dec_accept),
        .ren_src_a(ren_src_a), .ren_src_b(ren_src_b), .ren_dst(ren_dst),
        .ren_prev(ren_prev), .cm_valid(cm_valid), .cm_tag(cm_tag),
        .ckpt_save(ckpt_save), .ckpt_restore(ckpt_restore)
    );

    // {valid, sa, sb, dst, has_dst, exp_accept, exp_a, exp_b, exp_dst, exp_prev}
    localparam logic [27:0] VEC [0:7] = '{
        {1'b1, 3'd1, 3'd2, 3'd3, 1'b1, 1'b1, 4'd1,  4'd2, 4'd8,  4'd3},
        {1'b1, 3'd3, 3'd3, 3'd3, 1'b1, 1'b1, 4'd8,  4'd8, 4'd9,  4'd8},
        {1'b1, 3'd3, 3'd0, 3'd0, 1'b0, 1'b1, 4'd9,  4'd0, 4'd0,  4'd0},
        {1'b1, 3'd5, 3'd3, 3'd5, 1'b1, 1'b1, 4'd5,  4'd9, 4'd10, 4'd5},
        {1'b0, 3'd5, 3'd3, 3'd5, 1'b1, 1'b0, 4'd10, 4'd9, 4'd0,  4'd0},
        {1'b1, 3'd5, 3'd0, 3'd7, 1'b1, 1'b1, 4'd10, 4'd0, 4'd11, 4'd7},
        {1'b1, 3'd7, 3'd1, 3'd2, 1'b1, 1'b0, 4'd11, 4'd1, 4'd0,  4'd0},
        {1'b1, 3'd7, 3'd6, 3'd0, 1'b0, 1'b1, 4'd11, 4'd6, 4'd0,  4'd0}
    };

    task automatic check(input string req, input string what,
                         input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [2:0] sa, input logic [2:0] sb,
                         input logic [2:0] d, input logic hd, input logic cv,
                         input logic [3:0] ct, input logic sv, input logic rs);
        @(negedge clk);
        dec_valid = v; dec_src_a = sa; dec_src_b = sb; dec_dst = d;
        dec_has_dst = hd; cm_valid = cv; cm_tag = ct;
        ckpt_save = sv; ckpt_restore = rs;
        #1;
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        dec_valid = 0; dec_src_a = 0; dec_src_b = 0; dec_dst = 0; dec_has_dst = 0;
        cm_valid = 0; cm_tag = 0; ckpt_save = 0; ckpt_restore = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: identity map after reset, nothing accepted while idle
        for (int i = 0; i < 8; i++) begin
            drive(0, 3'(i), 3'(7 - i), 0, 0, 0, 0, 0, 0);
            check("R1", "src_a", ren_src_a, 4'(i));
            check("R1", "src_b", ren_src_b, 4'(7 - i));
            check("R10", "accept", {3'b0, dec_accept}, 4'd0);
        end

        // Vector walk: R1 order, R2, R3, R4, R5, R6, R10
        for (int k = 0; k < 8; k++) begin
            drive(VEC[k][27], VEC[k][26:24], VEC[k][23:21], VEC[k][20:18],
                  VEC[k][17], 0, 0, 0, 0);
            check("R6", "accept", {3'b0, dec_accept}, {3'b0, VEC[k][16]});
            check("R2", "src_a", ren_src_a, VEC[k][15:12]);
            check("R3", "src_b", ren_src_b, VEC[k][11:8]);
            if (VEC[k][16] && VEC[k][17]) begin
                check("R4", "dst", ren_dst, VEC[k][7:4]);
                check("R4", "prev", ren_prev, VEC[k][3:0]);
            end
        end

        // R6: pool empty, same-cycle return does not unblock
        drive(1, 2, 0, 2, 1, 1, 4'd3, 0, 0);
        check("R6", "accept with push", {3'b0, dec_accept}, 4'd0);
        drive(1, 2, 0, 2, 1, 0, 0, 0, 0);
        check("R7", "accept", {3'b0, dec_accept}, 4'd1);
        check("R7", "dst", ren_dst, 4'd3);
        check("R4", "prev", ren_prev, 4'd2);

        // R7: FIFO order with push and pop together
        drive(0, 0, 0, 0, 0, 1, 4'd8, 0, 0);
        drive(0, 0, 0, 0, 0, 1, 4'd5, 0, 0);
        drive(1, 4, 0, 4, 1, 1, 4'd7, 0, 0);
        check("R7", "dst first", ren_dst, 4'd8);
        check("R7", "prev", ren_prev, 4'd4);
        drive(1, 6, 0, 6, 1, 0, 0, 0, 0);
        check("R7", "dst second", ren_dst, 4'd5);
        drive(1, 1, 0, 1, 1, 0, 0, 0, 0);
        check("R7", "dst same-cycle push", ren_dst, 4'd7);
        check("R7", "prev", ren_prev, 4'd1);

        // R8 / R9: checkpoint, allocate past it, restore
        drive(0, 0, 0, 0, 0, 1, 4'd2, 0, 0);
        drive(0, 0, 0, 0, 0, 1, 4'd4, 0, 0);
        drive(1, 0, 0, 0, 1, 0, 0, 1, 0);
        check("R8", "dst at save", ren_dst, 4'd2);
        drive(1, 0, 0, 0, 1, 0, 0, 0, 0);
        check("R8", "src after save", ren_src_a, 4'd2);
        check("R8", "dst after save", ren_dst, 4'd4);
        drive(1, 0, 0, 3, 1, 0, 0, 0, 1);
        check("R9", "accept in restore", {3'b0, dec_accept}, 4'd0);
        drive(1, 0, 0, 3, 1, 0, 0, 0, 0);
        check("R9", "accept in recover", {3'b0, dec_accept}, 4'd0);
        drive(1, 0, 0, 3, 1, 0, 0, 0, 0);
        check("R9", "accept after recover", {3'b0, dec_accept}, 4'd1);
        check("R9", "restored map", ren_src_a, 4'd2);
        check("R9", "restored pool", ren_dst, 4'd4);
        check("R9", "prev", ren_prev, 4'd9);

        drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule